// File: doc/BRIEF.md
# Motor Speed-Lock Phase Comparator

This block is the digital heart of a loop that holds a motor at a fixed speed. A crystal-derived system clock is divided down by one of three selectable ratios, and the result leaves the block on its own pin. The comparator does not take its reference from that pin. It takes it from a separate reference input, so the divided clock can be looped back directly or passed through an external divider first.

The motor's tachometer (FG) signal is edge-detected in one of two ways. In the first, only falling edges count. In the second, both edges count, so at lock the motor runs at half the reference frequency. A tri-state phase/frequency detector compares falling reference edges with FG events. It drives up and down pulses whose width follows the phase difference, for an external loop filter.

A lock qualifier watches the phase error measured at each comparison. It raises a lock flag, with an inverted copy, after a run of consecutive comparisons that fall inside a programmable window. A single comparison outside the window drops the flag. Lock is judged on edge phase only, never on speed.

Top module: `speed_lock_pfd`

## Requirements
- R1: The divider ratio follows `ratio_sel`. 2'b01 gives 1024, 2'b00 gives 3072, and 2'b10 or 2'b11 give 4096 (the undriven input reads high). `div_clk` repeats with that many system-clock cycles between rising edges.
- R2: Any change of `ratio_sel` restarts the divider. `div_clk` is low in the cycle after the change is sampled. It then stays low for ratio/2 cycles in total before rising.
- R3: The comparator uses only `ref_in`. A running `div_clk` with `ref_in` and `fg_in` held steady produces no `pd_up` or `pd_dn` pulse.
- R4: A falling edge on `ref_in` sets `pd_up`. `pd_up` is first high after the third rising clock edge that samples the new low level (two synchronizer stages and one register). Rising edges of `ref_in` have no effect.
- R5: With `fg_both` low, only falling edges of `fg_in` set `pd_dn`. With `fg_both` high, rising and falling edges both do, so lock occurs with `fg_in` at half the reference frequency.
- R6: When `pd_up` and `pd_dn` are both high, both clear on the next clock unless a new event arrives in that cycle. For an FG event lagging the reference event by d cycles, `pd_up` is high for d+1 cycles and `pd_dn` for 1 cycle.
- R7: The phase error of a comparison is the number of cycles during which exactly one of `pd_up` and `pd_dn` was high. `lock` rises after 8 consecutive comparisons whose error is at most `lock_win`. `lock_n` is always the inverse of `lock`.
- R8: One comparison with an error greater than `lock_win` clears `lock` on the next clock and restarts the run of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, standing in for the crystal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Divider ratio select: 00 = 3072, 01 = 1024, 1x = 4096 |
| ref_in | input | 1 | Reference clock for the comparator (falling edge used) |
| fg_in | input | 1 | Motor tachometer signal |
| fg_both | input | 1 | 0: falling FG edges only; 1: both FG edges |
| lock_win | input | 8 | Largest phase error, in cycles, that still counts as in lock |
| div_clk | output | 1 | Divided system clock |
| pd_up | output | 1 | Phase-error pulse, reference leading |
| pd_dn | output | 1 | Phase-error pulse, FG leading |
| lock | output | 1 | High when phase lock is held |
| lock_n | output | 1 | Inverse of `lock` |

## Verification
A corrupted divider count shows on `div_clk` within one ratio period as a wrong high or low length. A missed restart shows as a first low phase of the wrong length after a `ratio_sel` change. A stuck or lost comparator state shows within one reference period as a `pd_up` or `pd_dn` width that no longer equals the lag plus one, or as a pulse that never clears. A wrong error count or run counter only shows at a comparison boundary, as `lock` moving one comparison early or late. The bench therefore compares every output against a behavioural model on every cycle, so the first divergent cycle is reported.

// File: rtl/speed_lock_pfd.sv
module speed_lock_pfd #(
  parameter int DIV_LO    = 3072,
  parameter int DIV_MID   = 1024,
  parameter int DIV_HI    = 4096,
  parameter int WIN_W     = 8,
  parameter int LOCK_RUNS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ratio_sel,
  input  logic             ref_in,
  input  logic             fg_in,
  input  logic             fg_both,
  input  logic [WIN_W-1:0] lock_win,
  output logic             div_clk,
  output logic             pd_up,
  output logic             pd_dn,
  output logic             lock,
  output logic             lock_n
);
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? ((DIV_HI > DIV_MID) ? DIV_HI : DIV_MID)
                                             : ((DIV_LO > DIV_MID) ? DIV_LO : DIV_MID);
  localparam int CNT_W = $clog2(DIV_MAX);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);

  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   ratio;
  logic [2:0]       ref_sh, fg_sh;
  logic             ref_fall, fg_ev, both;
  logic [WIN_W-1:0] err_cnt;
  logic [RUN_W-1:0] run_cnt;

  always_comb begin
    case (sel_q)
      2'b00:   ratio = (CNT_W+1)'(DIV_LO);
      2'b01:   ratio = (CNT_W+1)'(DIV_MID);
      default: ratio = (CNT_W+1)'(DIV_HI);
    endcase
  end

  assign div_clk = {1'b0, cnt} >= (ratio >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b10;
      cnt   <= '0;
    end else begin
      sel_q <= ratio_sel;
      if (ratio_sel != sel_q || {1'b0, cnt} == ratio - 1'b1) cnt <= '0;
      else                                                   cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      fg_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_in};
      fg_sh  <= {fg_sh[1:0], fg_in};
    end
  end

  assign ref_fall = ref_sh[2] & ~ref_sh[1];
  assign fg_ev    = fg_both ? (fg_sh[2] ^ fg_sh[1]) : (fg_sh[2] & ~fg_sh[1]);
  assign both     = pd_up & pd_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_up <= 1'b0;
      pd_dn <= 1'b0;
    end else begin
      pd_up <= (pd_up & ~both) | ref_fall;
      pd_dn <= (pd_dn & ~both) | fg_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (both) begin
      err_cnt <= '0;
      if (err_cnt <= lock_win) begin
        if (run_cnt != RUN_W'(LOCK_RUNS)) run_cnt <= run_cnt + 1'b1;
        lock <= run_cnt >= RUN_W'(LOCK_RUNS - 1);
      end else begin
        run_cnt <= '0;
        lock    <= 1'b0;
      end
    end else if ((pd_up ^ pd_dn) && err_cnt != '1) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  assign lock_n = ~lock;
endmodule

// File: rtl/speed_lock_pfd_chk.sv
module speed_lock_pfd_chk #(
  parameter int WIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ratio_sel,
  input logic [1:0]       sel_q,
  input logic             div_clk,
  input logic             ref_fall,
  input logic             fg_ev,
  input logic             pd_up,
  input logic             pd_dn,
  input logic [WIN_W-1:0] err_cnt,
  input logic [WIN_W-1:0] lock_win,
  input logic             lock
);
  assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel != sel_q) |=> !div_clk);

  assert_up_on_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |=> pd_up);

  assert_dn_on_fg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fg_ev |=> pd_dn);

  assert_pair_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_up && pd_dn && !ref_fall && !fg_ev) |=> (!pd_up && !pd_dn));

  assert_lock_at_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(pd_up && pd_dn));

  assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_up && pd_dn && err_cnt > lock_win) |=> !lock);
endmodule

bind speed_lock_pfd speed_lock_pfd_chk #(.WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .sel_q(sel_q),
  .div_clk(div_clk), .ref_fall(ref_fall), .fg_ev(fg_ev), .pd_up(pd_up),
  .pd_dn(pd_dn), .err_cnt(err_cnt), .lock_win(lock_win), .lock(lock)
);

// File: tb/test_speed_lock_pfd.sv
`timescale 1ns/1ps
module test_speed_lock_pfd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b01;
  logic       ref_in = 1'b0, fg_in = 1'b0, fg_both = 1'b0;
  logic [7:0] lock_win = 8'd4;
  logic       div_clk, pd_up, pd_dn, lock, lock_n;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  speed_lock_pfd i_speed_lock_pfd (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .ref_in(ref_in),
    .fg_in(fg_in), .fg_both(fg_both), .lock_win(lock_win),
    .div_clk(div_clk), .pd_up(pd_up), .pd_dn(pd_dn), .lock(lock), .lock_n(lock_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_err = 0, m_runs = 0;
  logic [1:0] m_sel = 2'b10;
  bit m_up = 0, m_dn = 0, m_lock = 0;
  bit rh[$] = '{0, 0, 0};
  bit fh[$] = '{0, 0, 0};

  function automatic int ratio_of(logic [1:0] s);
    if (s == 2'b00) return 3072;
    if (s == 2'b01) return 1024;
    return 4096;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 2'b10; m_up = 0; m_dn = 0; m_err = 0; m_runs = 0; m_lock = 0;
      rh = '{0, 0, 0}; fh = '{0, 0, 0};
    end else begin
      bit rf, fe, pair;
      rf = rh[2] && !rh[1];
      fe = fg_both ? (fh[2] != fh[1]) : (fh[2] && !fh[1]);
      pair = m_up && m_dn;
      if (pair) begin
        if (m_err <= int'(lock_win)) begin
          if (m_runs < 8) m_runs++;
          m_lock = (m_runs >= 8);
        end else begin
          m_runs = 0; m_lock = 0;
        end
        m_err = 0;
      end else if (m_up != m_dn && m_err < 255) m_err++;
      m_up = (m_up && !pair) || rf;
      m_dn = (m_dn && !pair) || fe;
      rh.push_front(ref_in); void'(rh.pop_back());
      fh.push_front(fg_in);  void'(fh.pop_back());
      if (ratio_sel != m_sel || m_cnt == ratio_of(m_sel) - 1) m_cnt = 0;
      else m_cnt++;
      m_sel = ratio_sel;
    end
  end

  always @(negedge clk) begin
    logic [4:0] got, exp;
    got = {div_clk, pd_up, pd_dn, lock, lock_n};
    exp = {m_cnt >= ratio_of(m_sel) / 2, m_up, m_dn, m_lock, !m_lock};
    check(got === exp, "cycle model R6 R7", int'(got), int'(exp));
  end

  task automatic measure_period(input logic [1:0] s, input int exp, input string tag);
    int n;
    logic prev;
    @(negedge clk) ratio_sel = s;
    @(negedge clk);
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);
    prev = 1'b1; n = 0;
    forever begin
      @(negedge clk); n++;
      if (div_clk && !prev) break;
      prev = div_clk;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic drive(input int p, input int off, input int n, input bit half,
                       output int ups, output int dns);
    ups = 0; dns = 0;
    for (int i = 0; i < n * p; i++) begin
      int j;
      @(negedge clk);
      if (i >= (n - 1) * p) begin
        ups += int'(pd_up);
        dns += int'(pd_dn);
      end
      j = i - off + 4 * p;
      ref_in = (i % p) < p / 2;
      fg_in  = half ? (((j + p / 2) / p) % 2 == 1) : ((j % p) < p / 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ups, dns, lows, quiet;
    repeat (3) @(negedge clk);
    check({div_clk, pd_up, pd_dn, lock, lock_n} == 5'b00001, "reset state R7", int'({div_clk, pd_up, pd_dn, lock, lock_n}), 1);
    rst_n = 1'b1;

    measure_period(2'b01, 1024, "R1 ratio mid");
    measure_period(2'b00, 3072, "R1 ratio low");
    measure_period(2'b10, 4096, "R1 ratio high");
    measure_period(2'b11, 4096, "R1 ratio undriven");

    // R2: restart on select change
    @(negedge clk) ratio_sel = 2'b01;
    @(negedge clk);
    while (!div_clk) @(negedge clk);
    ratio_sel = 2'b00;
    @(negedge clk);
    check(div_clk == 1'b0, "R2 low after change", int'(div_clk), 0);
    lows = 1;
    while (!div_clk) begin @(negedge clk); if (!div_clk) lows++; end
    check(lows == 1536, "R2 first low phase", lows, 1536);

    // R3/R4: held inputs with rising edges only, divider running
    ratio_sel = 2'b01;
    ref_in = 1'b1; fg_in = 1'b1;
    quiet = 0;
    repeat (3000) begin @(negedge clk); quiet += int'(pd_up | pd_dn); end
    check(quiet == 0, "R3 no pulse from div_clk, R4 rising ignored", quiet, 0);

    // R4 latency, R6 clear
    ref_in = 1'b0;
    @(negedge clk); check(pd_up == 0, "R4 latency edge1", int'(pd_up), 0);
    @(negedge clk); check(pd_up == 0, "R4 latency edge2", int'(pd_up), 0);
    @(negedge clk); check(pd_up == 1, "R4 latency edge3", int'(pd_up), 1);
    fg_in = 1'b0;
    repeat (3) @(negedge clk);
    check(pd_up && pd_dn, "R6 both set", int'(pd_up && pd_dn), 1);
    @(negedge clk);
    check(!pd_up && !pd_dn, "R6 both cleared", int'(pd_up | pd_dn), 0);

    // R7: lag equal to window locks
    drive(40, 4, 14, 0, ups, dns);
    check(lock == 1 && lock_n == 0, "R7 lock at lag=window", int'(lock), 1);
    check(ups == 5, "R6 up width lag+1", ups, 5);
    check(dns == 1, "R6 dn width", dns, 1);

    // R8: one step outside window
    drive(40, 5, 2, 0, ups, dns);
    check(lock == 0 && lock_n == 1, "R8 drop on window+1", int'(lock), 0);
    drive(40, 5, 12, 0, ups, dns);
    check(lock == 0, "R8 stays unlocked at window+1", int'(lock), 0);

    // R5: half-rate FG in single-edge mode does not lock; both-edge mode does
    drive(40, 2, 12, 1, ups, dns);
    check(lock == 0, "R5 single-edge half-rate no lock", int'(lock), 0);
    fg_both = 1'b1;
    drive(40, 2, 14, 1, ups, dns);
    check(lock == 1, "R5 both-edge half-rate lock", int'(lock), 1);
    check(ups == 3, "R5 both-edge up width", ups, 3);

    // R7: zero lag with zero window
    lock_win = 8'd0;
    drive(40, 0, 14, 1, ups, dns);
    check(lock == 1, "R7 zero lag zero window", int'(lock), 1);
    check(ups == 1 && dns == 1, "R6 coincident edges", ups + dns, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule